// File: doc/BRIEF.md
# Dual 32-bit Timer Register Bank

A memory-mapped timer made of two independent 32-bit counting halves, called lower and upper, together with a set of compare registers that watch the lower count. Software sets each half's limit and run mode through a simple 32-bit register port. Each half advances by one on every clock while it is allowed to run. When its count reaches its limit it returns to zero and pulses its own interrupt line.

A global word selects the overall timer arrangement and releases each half from reset. Only the split, unchained arrangement counts. The other arrangements leave both counters frozen. A shared enable word holds a 2-bit run field for each half: off, once, or continuous.

A compare register is armed when it is written. It raises the compare interrupt once, the next time the running lower count equals it. Software typically uses this by writing the current lower count plus a delay. With the limit at all ones, the lower half serves as a free-running wrap-around counter.

Top module: `dual_timer_bank`

## Requirements
- R1: After reset every register reads zero except the identity word at offset 0x00, which reads the ID parameter, and all three interrupt outputs are low.
- R2: Register offsets: lower count 0x10, upper count 0x14, lower limit 0x18, upper limit 0x1C, enable word 0x20, global word 0x24, compare k at 0x60+4k. Limits and compare registers read back what was written. Any other offset reads zero and ignores writes.
- R3: A half steps up by one per clock only when all three hold: the global mode field (bits 3:2) equals 1, its release bit (bit 0 lower, bit 1 upper) is 1, and its run field (enable bits 7:6 lower, 23:22 upper) is nonzero. Otherwise its count holds.
- R4: While a half's release bit is 0 its count is forced to zero, and writes to that count have no effect.
- R5: With run field 2 or 3 (continuous), the clock on which a running count equals its limit sets the count to zero and raises that half's interrupt for exactly that one following cycle.
- R6: With run field 1 (once), reaching the limit likewise zeroes the count and pulses the interrupt, and also clears the run field to 0, so the half stops.
- R7: A write to a count register loads the written value on that clock, taking priority over counting and over the limit match.
- R8: With the limit at 0xFFFFFFFF a running half wraps from 0xFFFFFFFF to 0 and pulses its interrupt.
- R9: Writing a compare register arms it. When the lower half is running and its count equals an armed compare value, the compare interrupt is high for the next cycle and that register disarms. A stopped lower half raises no compare interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one count tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_lo | output | 1 | Lower half limit interrupt pulse |
| irq_hi | output | 1 | Upper half limit interrupt pulse |
| irq_cmp | output | 1 | Compare match interrupt pulse |

## Verification
A wrong counter or run-field state appears on the read port on the next clock, because reads are combinational. A mis-handled limit or compare match shows as a missing, extra or late interrupt pulse in the cycle just after the match. The reference model is compared against every interrupt and the currently addressed register on every clock, so a divergence is caught within one cycle of the edge that caused it. Directed reads then confirm the once-mode self-clear, the release hold, ignored count writes and the all-ones wrap.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;

    localparam logic [7:0] OFS_ID     = 8'h00;
    localparam logic [7:0] OFS_CNT_LO = 8'h10;
    localparam logic [7:0] OFS_CNT_HI = 8'h14;
    localparam logic [7:0] OFS_LIM_LO = 8'h18;
    localparam logic [7:0] OFS_LIM_HI = 8'h1C;
    localparam logic [7:0] OFS_RUN    = 8'h20;
    localparam logic [7:0] OFS_GLB    = 8'h24;
    localparam logic [7:0] OFS_CMP0   = 8'h60;

    localparam int RUN_LO_POS = 6;
    localparam int RUN_HI_POS = 22;
    localparam int GM_POS     = 2;

    typedef enum logic [1:0] {
        RUN_OFF  = 2'd0,
        RUN_ONCE = 2'd1,
        RUN_CONT = 2'd2,
        RUN_ALT  = 2'd3
    } run_mode_e;

    typedef enum logic [1:0] {
        GM_WIDE  = 2'd0,
        GM_SPLIT = 2'd1,
        GM_GUARD = 2'd2,
        GM_CHAIN = 2'd3
    } glb_mode_e;

endpackage

// File: rtl/dtmr_half.sv
module dtmr_half
    import dtmr_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         split_ok,
    input  logic         rel,
    input  logic [1:0]   run,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    input  logic [W-1:0] lim,
    output logic [W-1:0] cnt,
    output logic         irq,
    output logic         active,
    output logic         expire
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         irq;
    } half_st_t;

    half_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        expire   = 1'b0;
        active   = split_ok && rel && (run != RUN_OFF);
        if (!rel) begin
            st_d.cnt = '0;
        end else if (ld) begin
            st_d.cnt = ld_val;
        end else if (active) begin
            if (st_q.cnt == lim) begin
                st_d.cnt = '0;
                st_d.irq = 1'b1;
                expire   = (run == RUN_ONCE);
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign irq = st_q.irq;

    AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rel |=> (cnt == '0)); // R4
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !ld && active && cnt != lim) |=> (cnt == $past(cnt) + 1'b1)); // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !ld && !active) |=> $stable(cnt)); // R3
    AST_WRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && !ld && active && cnt == lim) |=> (cnt == '0 && irq)); // R5
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (rel && ld) |=> (cnt == $past(ld_val) && !irq)); // R7

endmodule

// File: rtl/dtmr_cmp.sv
module dtmr_cmp #(
    parameter int W = 32,
    parameter int N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        wr,
    input  logic [W-1:0]        wr_val,
    input  logic [W-1:0]        cnt,
    input  logic                live,
    output logic [N-1:0][W-1:0] vals,
    output logic                irq
);

    typedef struct packed {
        logic [N-1:0][W-1:0] val;
        logic [N-1:0]        arm;
        logic                irq;
    } cmp_st_t;

    cmp_st_t      st_d, st_q;
    logic [N-1:0] hit;

    for (genvar k = 0; k < N; k++) begin : g_match
        assign hit[k] = st_q.arm[k] && live && (st_q.val[k] == cnt);
    end

    always_comb begin
        st_d     = st_q;
        st_d.irq = |hit;
        for (int k = 0; k < N; k++) begin
            if (wr[k]) begin
                st_d.val[k] = wr_val;
                st_d.arm[k] = 1'b1;
            end else if (hit[k]) begin
                st_d.arm[k] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign vals = st_q.val;
    assign irq  = st_q.irq;

    AST_CMP_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(live)); // R9
    AST_CMP_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && $past(wr) == '0) |-> ($countones(st_q.arm) < $countones($past(st_q.arm)))); // R9
    AST_WRITE_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wr) |=> ((st_q.arm & $past(wr)) == $past(wr))); // R9

endmodule

// File: rtl/dual_timer_bank.sv
module dual_timer_bank
    import dtmr_pkg::*;
#(
    parameter logic [31:0] ID   = 32'h5D71_0C02,
    parameter int          NCMP = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq_lo,
    output logic        irq_hi,
    output logic        irq_cmp
);

    localparam int W = 32;

    typedef struct packed {
        logic [1:0][W-1:0] lim;
        logic [1:0][1:0]   run;
        logic [1:0]        gmode;
        logic [1:0]        rel;
    } ctl_st_t;

    ctl_st_t ctl_d, ctl_q;

    logic [1:0][W-1:0]      cnt;
    logic [1:0]             irq;
    logic [1:0]             act;
    logic [1:0]             expire;
    logic [NCMP-1:0]        cmp_wr;
    logic [NCMP-1:0][W-1:0] cmp_vals;
    logic                   split_ok;
    logic                   run_wr;

    assign split_ok = (ctl_q.gmode == GM_SPLIT);
    assign run_wr   = bus_we && (bus_addr == OFS_RUN);

    for (genvar h = 0; h < 2; h++) begin : g_half
        localparam logic [7:0] CNT_OFS = (h == 0) ? OFS_CNT_LO : OFS_CNT_HI;
        dtmr_half #(.W(W)) u_half (
            .clk      (clk),
            .rst_n    (rst_n),
            .split_ok (split_ok),
            .rel      (ctl_q.rel[h]),
            .run      (ctl_q.run[h]),
            .ld       (bus_we && bus_addr == CNT_OFS),
            .ld_val   (bus_wdata),
            .lim      (ctl_q.lim[h]),
            .cnt      (cnt[h]),
            .irq      (irq[h]),
            .active   (act[h]),
            .expire   (expire[h])
        );
    end

    for (genvar k = 0; k < NCMP; k++) begin : g_cmp_dec
        assign cmp_wr[k] = bus_we && (bus_addr == OFS_CMP0 + 8'(4 * k));
    end

    dtmr_cmp #(.W(W), .N(NCMP)) u_cmp (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (cmp_wr),
        .wr_val (bus_wdata),
        .cnt    (cnt[0]),
        .live   (act[0]),
        .vals   (cmp_vals),
        .irq    (irq_cmp)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (bus_we && bus_addr == OFS_LIM_LO) ctl_d.lim[0] = bus_wdata;
        if (bus_we && bus_addr == OFS_LIM_HI) ctl_d.lim[1] = bus_wdata;
        if (bus_we && bus_addr == OFS_GLB) begin
            ctl_d.gmode = bus_wdata[GM_POS +: 2];
            ctl_d.rel   = bus_wdata[1:0];
        end
        if (run_wr) begin
            ctl_d.run[0] = bus_wdata[RUN_LO_POS +: 2];
            ctl_d.run[1] = bus_wdata[RUN_HI_POS +: 2];
        end else begin
            for (int h = 0; h < 2; h++) begin
                if (expire[h]) ctl_d.run[h] = RUN_OFF;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_ID:     bus_rdata = ID;
            OFS_CNT_LO: bus_rdata = cnt[0];
            OFS_CNT_HI: bus_rdata = cnt[1];
            OFS_LIM_LO: bus_rdata = ctl_q.lim[0];
            OFS_LIM_HI: bus_rdata = ctl_q.lim[1];
            OFS_RUN: begin
                bus_rdata[RUN_LO_POS +: 2] = ctl_q.run[0];
                bus_rdata[RUN_HI_POS +: 2] = ctl_q.run[1];
            end
            OFS_GLB: begin
                bus_rdata[GM_POS +: 2] = ctl_q.gmode;
                bus_rdata[1:0]         = ctl_q.rel;
            end
            default: begin
                for (int k = 0; k < NCMP; k++) begin
                    if (bus_addr == OFS_CMP0 + 8'(4 * k)) bus_rdata = cmp_vals[k];
                end
            end
        endcase
    end

    assign irq_lo = irq[0];
    assign irq_hi = irq[1];

    AST_ONCE_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (expire[0] && !run_wr) |=> (ctl_q.run[0] == RUN_OFF)); // R6
    AST_ONCE_SELF_CLEAR_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (expire[1] && !run_wr) |=> (ctl_q.run[1] == RUN_OFF)); // R6
    AST_HI_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hi |-> $past(act[1])); // R3
    AST_LO_IRQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_lo |-> $past(act[0])); // R3

endmodule

// File: tb/dual_timer_bank_test.sv
`timescale 1ns/1ps
module dual_timer_bank_test;

    localparam logic [31:0] ID = 32'h5D71_0C02;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_lo, irq_hi, irq_cmp;

    int n_vec = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dual_timer_bank #(.ID(ID), .NCMP(8)) uut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_cmp(irq_cmp)
    );

    // behavioural reference state
    logic [31:0] m_cnt [2];
    logic [31:0] m_lim [2];
    logic [1:0]  m_run [2];
    logic [1:0]  m_gm;
    logic [1:0]  m_rel;
    logic [31:0] m_cmp [8];
    bit          m_arm [8];
    bit          m_irq [2];
    bit          m_cirq;

    function automatic logic [31:0] m_read(input logic [7:0] a);
        logic [31:0] r = '0;
        if (a == 8'h00) r = ID;
        else if (a == 8'h10) r = m_cnt[0];
        else if (a == 8'h14) r = m_cnt[1];
        else if (a == 8'h18) r = m_lim[0];
        else if (a == 8'h1C) r = m_lim[1];
        else if (a == 8'h20) r = (32'(m_run[1]) << 22) | (32'(m_run[0]) << 6);
        else if (a == 8'h24) r = {28'd0, m_gm, m_rel};
        else if (a >= 8'h60 && a <= 8'h7C && a[1:0] == 2'b00) r = m_cmp[(a - 8'h60) >> 2];
        return r;
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        if (a == 8'h00) return "R1";
        if (a == 8'h10 || a == 8'h14) return "R3";
        if (a == 8'h20) return "R6";
        if (a >= 8'h60) return "R9";
        return "R2";
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < 2; i++) begin
                m_cnt[i] = 0; m_lim[i] = 0; m_run[i] = 0; m_irq[i] = 0;
            end
            for (int k = 0; k < 8; k++) begin
                m_cmp[k] = 0; m_arm[k] = 0;
            end
            m_gm = 0; m_rel = 0; m_cirq = 0;
        end else begin
            bit lo_go;
            bit go [2];
            bit fin [2];
            for (int i = 0; i < 2; i++) go[i] = (m_gm == 2'd1) && m_rel[i] && (m_run[i] != 0);
            lo_go = go[0];
            m_cirq = 0;
            for (int k = 0; k < 8; k++) begin
                if (m_arm[k] && lo_go && m_cmp[k] == m_cnt[0]) begin
                    m_cirq = 1;
                    m_arm[k] = 0;
                end
            end
            for (int i = 0; i < 2; i++) begin
                m_irq[i] = 0;
                fin[i] = 0;
                if (!m_rel[i]) m_cnt[i] = 0;
                else if (bus_we && bus_addr == (i == 0 ? 8'h10 : 8'h14)) m_cnt[i] = bus_wdata;
                else if (go[i]) begin
                    if (m_cnt[i] == m_lim[i]) begin
                        m_cnt[i] = 0;
                        m_irq[i] = 1;
                        fin[i] = (m_run[i] == 2'd1);
                    end else m_cnt[i] = m_cnt[i] + 1;
                end
            end
            if (bus_we) begin
                if (bus_addr == 8'h18) m_lim[0] = bus_wdata;
                if (bus_addr == 8'h1C) m_lim[1] = bus_wdata;
                if (bus_addr == 8'h24) begin
                    m_gm = bus_wdata[3:2];
                    m_rel = bus_wdata[1:0];
                end
                if (bus_addr >= 8'h60 && bus_addr <= 8'h7C && bus_addr[1:0] == 2'b00) begin
                    m_cmp[(bus_addr - 8'h60) >> 2] = bus_wdata;
                    m_arm[(bus_addr - 8'h60) >> 2] = 1;
                end
            end
            if (bus_we && bus_addr == 8'h20) begin
                m_run[0] = bus_wdata[7:6];
                m_run[1] = bus_wdata[23:22];
            end else begin
                for (int i = 0; i < 2; i++) if (fin[i]) m_run[i] = 0;
            end
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            n_vec++;
            if (irq_lo !== m_irq[0] || irq_hi !== m_irq[1]) begin
                n_bad++;
                $display("FAIL R5 limit irqs actual=%b%b expected=%b%b at %0t",
                         irq_hi, irq_lo, m_irq[1], m_irq[0], $time);
            end
            if (irq_cmp !== m_cirq) begin
                n_bad++;
                $display("FAIL R9 irq_cmp actual=%b expected=%b at %0t", irq_cmp, m_cirq, $time);
            end
            if (bus_rdata !== m_read(bus_addr)) begin
                n_bad++;
                $display("FAIL %s read @%h actual=%h expected=%h at %0t",
                         tag_of(bus_addr), bus_addr, bus_rdata, m_read(bus_addr), $time);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] a, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        n_vec++;
        if (bus_rdata !== m_read(a)) begin
            n_bad++;
            $display("FAIL %s @%h actual=%h expected=%h", tag, a, bus_rdata, m_read(a));
        end
    endtask

    task automatic chk_val(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        n_vec++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s @%h actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog actual=hung expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        chk_val(8'h00, ID, "R1");
        chk_val(8'h10, 32'h0, "R1");
        chk_val(8'h20, 32'h0, "R1");
        chk_val(8'h24, 32'h0, "R1");
        // R2: map and unmapped offsets
        wr(8'h18, 32'd5);
        wr(8'h08, 32'hDEAD_BEEF);
        chk_val(8'h18, 32'd5, "R2");
        chk_val(8'h08, 32'h0, "R2");
        chk_val(8'h40, 32'h0, "R2");
        // R5: continuous run on lower half
        wr(8'h24, 32'h7);
        wr(8'h20, 32'h2 << 6);
        idle(15);
        chk(8'h10, "R5");
        // R3: run field off holds the count
        wr(8'h20, 32'h0);
        idle(4);
        chk(8'h10, "R3");
        // R5: run value 3 also continuous
        wr(8'h20, 32'h3 << 6);
        idle(9);
        // R7: count write overrides counting
        wr(8'h10, 32'd3);
        chk(8'h10, "R7");
        // R6: once mode self clears
        wr(8'h20, 32'h0);
        wr(8'h10, 32'd0);
        wr(8'h20, 32'h1 << 6);
        idle(10);
        chk_val(8'h20, 32'h0, "R6");
        chk_val(8'h10, 32'h0, "R6");
        // R8: upper half all-ones wrap
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFF0);
        wr(8'h20, 32'h2 << 22);
        idle(20);
        chk(8'h14, "R8");
        // R3: wrong global mode freezes counting
        wr(8'h24, 32'h3);
        chk(8'h14, "R3");
        idle(3);
        chk(8'h14, "R3");
        // R4: released-low half held at zero, writes ignored
        wr(8'h24, 32'h6);
        wr(8'h10, 32'd77);
        chk_val(8'h10, 32'h0, "R4");
        // R9: compare matches on the lower half
        wr(8'h24, 32'h7);
        wr(8'h20, 32'h0);
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h10, 32'd100);
        wr(8'h60, 32'd110);
        wr(8'h6C, 32'd105);
        chk_val(8'h6C, 32'd105, "R2");
        wr(8'h64, 32'd100);
        idle(3);
        wr(8'h20, 32'h2 << 6);
        idle(20);
        chk(8'h10, "R9");
        wr(8'h20, 32'h0);
        wr(8'h70, 32'd0);
        chk(8'h70, "R9");
        idle(5);
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule